// File: doc/BRIEF.md
# Receive Buffer Bypass Sequencer

This block runs the phase-alignment procedure that a serial receiver needs when its elastic buffer is bypassed. It sits in the receive user clock domain. One instance can control one lane or a group of lanes. In a group, one lane is the master and the others are slaves. The user side is always one bit wide: a synchronous reset, a trigger taken from the upstream reset-done signal, a manual restart pulse, and a done/error result pair. The transceiver side is one bit per lane: a delay-reset request going out, and delay-reset-done and phase-align-done status coming back.

A run starts on a rising edge of the upstream reset-done signal. The block then holds the delay-reset request on every lane for a fixed number of cycles and waits for all lanes to report delay-reset-done. Next it waits for the master lane's phase-align-done to rise, and then for every lane to show phase-align-done. Each wait state is bounded by a watchdog. Once the first run has finished, a single-cycle start pulse repeats the procedure. The outcome is read from the done and error outputs together.

Top module: `rx_bypass_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. `done_out`, `error_out` and every bit of `dly_rst_req_out` are 0 after that edge.
- R2: A 0-to-1 transition on `rst_done_in` starts a run when no run is active. Holding the input high afterwards does not start another run.
- R3: A one-cycle pulse on `start_in` is ignored until a run has finished since the last reset. After that, the pulse starts a new run.
- R4: Starting a run clears `done_out` and `error_out` to 0 on the next cycle. Whenever `error_out` is 1, `done_out` is also 1.
- R5: A run first drives `dly_rst_req_out` to all ones for exactly `PULSE_LEN` consecutive cycles. It then waits until every bit of `dly_rst_done_in` is 1.
- R6: After the delay-reset wait, the block waits for a rising edge on the master lane's `align_done_in` bit. It then waits until all bits are 1, and finishes with `done_out`=1 and `error_out`=0. The result pair decodes as follows: 1/0 means success, 1/1 means failure, and 0/x means not finished.
- R7: If any wait state lasts `WDOG_LIMIT` cycles, the run ends with `done_out`=1 and `error_out`=1.
- R8: After a successful finish, any `align_done_in` bit going low sets `error_out` to 1. `error_out` then stays 1 until the next reset or run start, even if the bit returns high.
- R9: Only the lane at index `MASTER_IDX` advances the master wait. Slave lanes that report phase-align-done first do not end the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock (master lane's clock) |
| rst | input | 1 | Synchronous active-high reset |
| rst_done_in | input | 1 | Upstream reset-done; its rising edge triggers a run |
| start_in | input | 1 | One-cycle manual restart request |
| done_out | output | 1 | Procedure finished |
| error_out | output | 1 | Procedure failed, or alignment was lost after success |
| dly_rst_req_out | output | LANES | Per-lane delay-reset request |
| dly_rst_done_in | input | LANES | Per-lane delay-reset-done status |
| align_done_in | input | LANES | Per-lane phase-align-done status |

## Verification
The hardest state to reach from the ports is loss of alignment after a successful finish. It needs a complete run to succeed first, followed by a slave lane status dropping while done is held. The bench plays the lane responder in each task. It completes a run with the slave lanes raised before the master, which also shows that slaves alone do not advance the sequence. It then lowers one slave and raises it again to show the error stays set. The watchdog path is reached by never answering the delay-reset request, using a small `WDOG_LIMIT`.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRST,
        ST_WAIT_DRST,
        ST_WAIT_MST,
        ST_WAIT_ALL,
        ST_FIN
    } seq_st_e;
endpackage

// File: rtl/rxbp_sync.sv
module rxbp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = d;
        sync_d = meta_q;
        if (rst) begin
            meta_d = '0;
            sync_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        meta_q <= meta_d;
        sync_q <= sync_d;
    end

    assign q = sync_q;
endmodule

// File: rtl/rxbp_wdog.sv
module rxbp_wdog #(
    parameter int LIMIT = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (rst || clr) begin
            cnt_d = '0;
        end else if (en && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q >= LAST);

    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP); // R7
endmodule

// File: rtl/rx_bypass_seq.sv
module rx_bypass_seq #(
    parameter int LANES      = 1,
    parameter int MASTER_IDX = 0,
    parameter int PULSE_LEN  = 4,
    parameter int WDOG_LIMIT = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_done_in,
    input  logic             start_in,
    output logic             done_out,
    output logic             error_out,
    output logic [LANES-1:0] dly_rst_req_out,
    input  logic [LANES-1:0] dly_rst_done_in,
    input  logic [LANES-1:0] align_done_in
);
    import rxbp_pkg::*;

    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PULSE_LEN - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [PW-1:0] pcnt;
        logic          done;
        logic          err;
        logic          first;
        logic          trig_prev;
        logic          mst_prev;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    logic             trig_s;
    logic [LANES-1:0] drst_s;
    logic [LANES-1:0] align_s;
    logic             wd_exp;
    logic             wd_clr;
    logic             wd_en;
    logic             trig_rise;
    logic             mst_rise;
    logic             busy;
    logic             go;

    rxbp_sync #(.W(1)) u_sync_trig (
        .clk(clk), .rst(rst), .d(rst_done_in), .q(trig_s)
    );
    rxbp_sync #(.W(LANES)) u_sync_drst (
        .clk(clk), .rst(rst), .d(dly_rst_done_in), .q(drst_s)
    );
    rxbp_sync #(.W(LANES)) u_sync_align (
        .clk(clk), .rst(rst), .d(align_done_in), .q(align_s)
    );

    rxbp_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk(clk), .rst(rst), .clr(wd_clr), .en(wd_en), .expired(wd_exp)
    );

    assign trig_rise = trig_s & ~r_q.trig_prev;
    assign mst_rise  = align_s[MASTER_IDX] & ~r_q.mst_prev;
    assign busy      = (r_q.st == ST_DRST) || (r_q.st == ST_WAIT_DRST) ||
                       (r_q.st == ST_WAIT_MST) || (r_q.st == ST_WAIT_ALL);
    assign go        = !busy && (trig_rise || (start_in && r_q.first));
    assign wd_en     = (r_q.st == ST_WAIT_DRST) || (r_q.st == ST_WAIT_MST) ||
                       (r_q.st == ST_WAIT_ALL);
    assign wd_clr    = (r_d.st != r_q.st);

    always_comb begin
        r_d           = r_q;
        r_d.trig_prev = trig_s;
        r_d.mst_prev  = align_s[MASTER_IDX];
        case (r_q.st)
            ST_IDLE, ST_FIN: begin
                if (go) begin
                    r_d.st   = ST_DRST;
                    r_d.pcnt = '0;
                    r_d.done = 1'b0;
                    r_d.err  = 1'b0;
                end else if (r_q.st == ST_FIN && r_q.done && !r_q.err && !(&align_s)) begin
                    r_d.err = 1'b1;
                end
            end
            ST_DRST: begin
                r_d.pcnt = r_q.pcnt + 1'b1;
                if (r_q.pcnt == PLAST) begin
                    r_d.st = ST_WAIT_DRST;
                end
            end
            ST_WAIT_DRST: begin
                if (&drst_s) begin
                    r_d.st = ST_WAIT_MST;
                end else if (wd_exp) begin
                    r_d.st    = ST_FIN;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.first = 1'b1;
                end
            end
            ST_WAIT_MST: begin
                if (mst_rise) begin
                    r_d.st = ST_WAIT_ALL;
                end else if (wd_exp) begin
                    r_d.st    = ST_FIN;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.first = 1'b1;
                end
            end
            ST_WAIT_ALL: begin
                if (&align_s) begin
                    r_d.st    = ST_FIN;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.first = 1'b1;
                end else if (wd_exp) begin
                    r_d.st    = ST_FIN;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.first = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (rst) begin
            r_d = '{st: ST_IDLE, pcnt: '0, done: 1'b0, err: 1'b0,
                    first: 1'b0, trig_prev: 1'b0, mst_prev: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign done_out        = r_q.done;
    assign error_out       = r_q.err;
    assign dly_rst_req_out = {LANES{r_q.st == ST_DRST}};

    AST_REQ_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dly_rst_req_out == '0 && !done_out && !error_out)); // R1
    AST_ERR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
        error_out |-> done_out); // R4
    AST_GO_CLEARS_RESULT: assert property (@(posedge clk) disable iff (rst)
        go |=> (!done_out && !error_out)); // R4
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !r_q.first && !trig_rise) |=> r_q.st == ST_IDLE); // R3
    AST_OK_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_out) && !error_out) |-> $past(&align_s)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_out && error_out && !go) |=> error_out); // R8
endmodule

// File: tb/tb_rx_bypass_seq.sv
`timescale 1ns/1ps
module tb_rx_bypass_seq;
    localparam int N     = 3;
    localparam int M     = 1;
    localparam int PULSE = 4;
    localparam int WDOG  = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rst_done_in = 1'b0;
    logic         start_in = 1'b0;
    logic         done_out;
    logic         error_out;
    logic [N-1:0] dly_rst_req_out;
    logic [N-1:0] dly_rst_done_in = '0;
    logic [N-1:0] align_done_in = '0;

    int errors = 0;
    int checks = 0;
    int req_cyc = 0;
    int req_bad = 0;

    always #4 clk = ~clk;

    rx_bypass_seq #(.LANES(N), .MASTER_IDX(M), .PULSE_LEN(PULSE), .WDOG_LIMIT(WDOG)) dut (
        .clk(clk), .rst(rst), .rst_done_in(rst_done_in), .start_in(start_in),
        .done_out(done_out), .error_out(error_out), .dly_rst_req_out(dly_rst_req_out),
        .dly_rst_done_in(dly_rst_done_in), .align_done_in(align_done_in)
    );

    always @(negedge clk) begin
        if (dly_rst_req_out != '0) begin
            req_cyc++;
            if (dly_rst_req_out != '1) req_bad++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_in = 1'b1;
        cyc(1);
        start_in = 1'b0;
    endtask

    task automatic wait_done(input int lim, output int used);
        used = 0;
        while (!done_out && used < lim) begin
            cyc(1);
            used++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        check(done_out == 1'b0, "R1 done after reset", done_out, 0);
        check(error_out == 1'b0, "R1 error after reset", error_out, 0);
        check(dly_rst_req_out == '0, "R1 req after reset", dly_rst_req_out, 0);
    endtask

    task automatic t_early_start();
        int base;
        base = req_cyc;
        pulse_start();
        cyc(20);
        check(req_cyc == base, "R3 start ignored before first run", req_cyc - base, 0);
        check(done_out == 1'b0, "R3 no done from early start", done_out, 0);
    endtask

    task automatic t_auto_run();
        int base, used;
        base = req_cyc;
        rst_done_in = 1'b1;
        used = 0;
        while ((req_cyc - base < PULSE || dly_rst_req_out != '0) && used < 60) begin
            cyc(1);
            used++;
        end
        check(req_cyc - base == PULSE, "R5 request length", req_cyc - base, PULSE);
        check(req_bad == 0, "R5 request on all lanes", req_bad, 0);
        cyc(10);
        check(done_out == 1'b0, "R5 waits for delay-reset-done", done_out, 0);
        dly_rst_done_in = '1;
        align_done_in = '1;
        align_done_in[M] = 1'b0;
        cyc(20);
        check(done_out == 1'b0, "R9 slaves alone do not advance", done_out, 0);
        align_done_in[M] = 1'b1;
        wait_done(50, used);
        check(done_out == 1'b1, "R6 done after alignment", done_out, 1);
        check(error_out == 1'b0, "R6 success code", error_out, 0);
        base = req_cyc;
        cyc(30);
        check(req_cyc == base, "R2 held level gives no second run", req_cyc - base, 0);
    endtask

    task automatic t_drop();
        align_done_in[0] = 1'b0;
        cyc(6);
        check(error_out == 1'b1, "R8 error on lost alignment", error_out, 1);
        check(done_out == 1'b1, "R8 done kept", done_out, 1);
        align_done_in[0] = 1'b1;
        cyc(6);
        check(error_out == 1'b1, "R8 error sticky", error_out, 1);
    endtask

    task automatic t_restart();
        int base, used;
        dly_rst_done_in = '0;
        align_done_in = '0;
        cyc(4);
        base = req_cyc;
        pulse_start();
        cyc(2);
        check(done_out == 1'b0 && error_out == 1'b0, "R4 start clears result",
              {done_out, error_out}, 0);
        cyc(PULSE + 2);
        check(req_cyc - base == PULSE, "R3 restart drives request", req_cyc - base, PULSE);
        dly_rst_done_in = '1;
        cyc(4);
        align_done_in = '1;
        wait_done(50, used);
        check(done_out == 1'b1 && error_out == 1'b0, "R3 restarted run succeeds",
              {done_out, error_out}, 2);
    endtask

    task automatic t_timeout();
        int used;
        dly_rst_done_in = '0;
        align_done_in = '0;
        cyc(4);
        pulse_start();
        wait_done(500, used);
        check(done_out == 1'b1 && error_out == 1'b1, "R7 timeout failure code",
              {done_out, error_out}, 3);
        check(used >= WDOG, "R7 not before limit", used, WDOG);
        check(used <= WDOG + PULSE + 8, "R7 bounded wait", used, WDOG + PULSE + 8);
    endtask

    task automatic t_mid_reset();
        int base;
        pulse_start();
        cyc(2);
        rst = 1'b1;
        rst_done_in = 1'b0;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        check(done_out == 1'b0 && error_out == 1'b0, "R1 reset mid-run clears result",
              {done_out, error_out}, 0);
        check(dly_rst_req_out == '0, "R1 reset mid-run stops request", dly_rst_req_out, 0);
        base = req_cyc;
        cyc(10);
        check(req_cyc == base, "R2 low trigger stays idle", req_cyc - base, 0);
        rst_done_in = 1'b1;
        cyc(12);
        check(req_cyc - base == PULSE, "R2 new rising edge starts run", req_cyc - base, PULSE);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_early_start();
        t_auto_run();
        t_drop();
        t_restart();
        t_timeout();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule